// File: doc/BRIEF.md
# Dual-Mode Serial DAC Word Loader

This block takes 16-bit converter codes from a serial link and holds them in a parallel output register that drives a converter core. A static mode input selects one of two ways to load that register. Both ways share one input shift path.

In three-wire mode the host drives a data line, a serial clock and a latch request. Data moves into the shift register on each rising serial-clock edge, and the output register takes the shift register's contents only when a latch request arrives. The bit that falls off the far end of the register is driven on a serial output. Several loaders wired output-to-input therefore act as one long shift register.

In asynchronous mode the system clock runs at 16 times the bit rate, and the same data line carries framed bytes. Two good frames make one word, and that word loads with no latch strobe. For example, a 2.4 MHz clock serves a 150 kbit/s line. All inputs are taken on the system clock, and the serial clock and the latch request are edge-detected against it.

Top module: `serial_word_loader`

## Requirements
- R1: A synchronous active-low reset clears the shift register, the output register, the byte counter, the serial output and both error flags.
- R2: In three-wire mode (`mode_async`=0), `din` is shifted into bit 0 on each rising edge of `sclk` and earlier bits move toward bit 15. After 16 edges, the first bit sent sits in bit 15.
- R3: In three-wire mode, `dac_code` changes only on a rising edge of `latch_req`, and it then takes the shift register's contents.
- R4: An `sclk` rising edge seen while `latch_req` is high does not shift and sets `proto_err`, which stays set until reset. When `latch_req` and `sclk` rise in the same cycle, the latch takes the contents from before that edge and the edge is dropped.
- R5: `sdout` always equals bit 15 of the shift register. With two loaders chained, after 32 bits the first 16 sent sit in the far loader and the last 16 sit in the near one.
- R6: In asynchronous mode (`mode_async`=1), a frame is one low start bit, 8 data bits LSB first and one high stop bit, each lasting 16 clocks. The start bit is confirmed 8 clocks after the falling edge, and every later bit is sampled at its middle.
- R7: In asynchronous mode, the first good frame gives the high byte and the second gives the low byte. `dac_code` loads on its own once the second stop bit is valid, and not after the first frame.
- R8: A low stop bit sets `frame_err`, which stays set until reset. It drops any half-built word without loading `dac_code`, and the next good frame is taken as a high byte.
- R9: In asynchronous mode, `din` passes through a two-stage synchronizer. A start needs a high-to-low transition, so a line held low after a frame starts no new frame.
- R10: In asynchronous mode `sclk` and `latch_req` have no effect and `proto_err` stays 0. In three-wire mode, frames on `din` with no `sclk` edges load nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the 16x oversampling clock in asynchronous mode |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_async | input | 1 | Static mode select: 0 three-wire, 1 asynchronous |
| din | input | 1 | Serial data, shared by both modes |
| sclk | input | 1 | Three-wire serial clock, sampled by `clk` |
| latch_req | input | 1 | Three-wire latch request, active high |
| sdout | output | 1 | Bit shifted out of the far end, for chaining |
| dac_code | output | 16 | Parallel code to the converter core |
| proto_err | output | 1 | Sticky flag: serial clock edge during a latch request |
| frame_err | output | 1 | Sticky flag: low stop bit seen |

## Verification
In three-wire mode, a shift and a latch load can fall in the same system-clock cycle. The bench provokes this by raising `sclk` and `latch_req` at the same negative edge, after it has loaded a word whose bit 0 differs from the data bit being presented. It then judges the result three ways. `dac_code` must hold the word from before the edge, `proto_err` must be set, and a second latch must show that the shift register did not move. A chained pair of loaders and a framing error in the middle of a word cover the daisy chain and the recovery from a dropped word.

// File: rtl/slw_pkg.sv
package slw_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_t;
endpackage

// File: rtl/slw_sync.sv
module slw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("slw_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/slw_async_rx.sv
module slw_async_rx
   import slw_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rx,
   output logic              byte_valid,
   output logic              frame_bad,
   output logic [BYTE_W-1:0] byte_out
);
   localparam int CNT_W = $clog2(OSR);
   localparam int BIT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR/2 - 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

   rx_state_t         state;
   logic [CNT_W-1:0]  os_cnt;
   logic [BIT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              rx_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         os_cnt     <= '0;
         bit_cnt    <= '0;
         shreg      <= '0;
         rx_prev    <= 1'b1;
         byte_valid <= 1'b0;
         frame_bad  <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         frame_bad  <= 1'b0;
         rx_prev    <= rx;
         if (!en) begin
            state <= RX_IDLE;
         end else begin
            unique case (state)
               RX_IDLE: begin
                  if (rx_prev && !rx) begin
                     state  <= RX_START;
                     os_cnt <= '0;
                  end
               end
               RX_START: begin
                  if (os_cnt == CNT_MID) begin
                     os_cnt  <= '0;
                     bit_cnt <= '0;
                     state   <= rx ? RX_IDLE : RX_DATA;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (os_cnt == CNT_LAST) begin
                     os_cnt <= '0;
                     shreg  <= {rx, shreg[BYTE_W-1:1]};
                     if (bit_cnt == BIT_LAST) state <= RX_STOP;
                     else                     bit_cnt <= bit_cnt + 1'b1;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (os_cnt == CNT_LAST) begin
                     os_cnt     <= '0;
                     byte_valid <= rx;
                     frame_bad  <= !rx;
                     state      <= RX_IDLE;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   assign byte_out = shreg;
endmodule

// File: rtl/slw_shift_path.sv
module slw_shift_path #(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              bit_in,
   input  logic              byte_en,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [WORD_W-1:0] word
);
   always_ff @(posedge clk) begin
      if (!rst_n)       word <= '0;
      else if (byte_en) word <= {word[WORD_W-BYTE_W-1:0], byte_in};
      else if (bit_en)  word <= {word[WORD_W-2:0], bit_in};
   end
endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader #(
   parameter int WORD_W      = 16,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_async,
   input  logic              din,
   input  logic              sclk,
   input  logic              latch_req,
   output logic              sdout,
   output logic [WORD_W-1:0] dac_code,
   output logic              proto_err,
   output logic              frame_err
);
   localparam int BYTE_W = WORD_W / 2;

   generate
      if (WORD_W % 2 != 0 || WORD_W < 4) begin : g_bad_word
         $error("serial_word_loader: WORD_W must be even and at least 4");
      end
      if (OSR < 4) begin : g_bad_osr
         $error("serial_word_loader: OSR must be at least 4");
      end
   endgenerate

   logic              sclk_q, latch_q;
   logic              sclk_rise, latch_rise;
   logic              din_s;
   logic              rx_valid, rx_bad;
   logic [BYTE_W-1:0] rx_byte;
   logic [WORD_W-1:0] sr;
   logic              half_q;
   logic              sync_shift, sync_clash;

   // edge detectors track the pins across reset
   always_ff @(posedge clk) begin
      sclk_q  <= sclk;
      latch_q <= latch_req;
   end

   assign sclk_rise  = sclk && !sclk_q;
   assign latch_rise = latch_req && !latch_q;
   assign sync_shift = !mode_async && sclk_rise && !latch_req;
   assign sync_clash = !mode_async && sclk_rise && latch_req;

   slw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (din),
      .q     (din_s)
   );

   slw_async_rx #(.BYTE_W(BYTE_W), .OSR(OSR)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (mode_async),
      .rx         (din_s),
      .byte_valid (rx_valid),
      .frame_bad  (rx_bad),
      .byte_out   (rx_byte)
   );

   slw_shift_path #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_path (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (sync_shift),
      .bit_in  (din),
      .byte_en (mode_async && rx_valid),
      .byte_in (rx_byte),
      .word    (sr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dac_code  <= '0;
         half_q    <= 1'b0;
         proto_err <= 1'b0;
         frame_err <= 1'b0;
      end else if (mode_async) begin
         if (rx_bad) begin
            half_q    <= 1'b0;
            frame_err <= 1'b1;
         end else if (rx_valid) begin
            half_q <= !half_q;
            if (half_q) dac_code <= {sr[BYTE_W-1:0], rx_byte};
         end
      end else begin
         if (sync_clash) proto_err <= 1'b1;
         if (latch_rise) dac_code  <= sr;
      end
   end

   assign sdout = sr[WORD_W-1];
endmodule

// File: rtl/slw_checker.sv
module slw_checker #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_async,
   input logic              sclk,
   input logic              latch_req,
   input logic [WORD_W-1:0] dac_code,
   input logic              proto_err,
   input logic              frame_err
);
   assert_latch_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_async && !(latch_req && !$past(latch_req))) |=> $stable(dac_code));

   assert_proto_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

   assert_proto_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_async && sclk && !$past(sclk) && latch_req) |=> proto_err);

   assert_frame_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);

   assert_frame_noload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> $stable(dac_code));

   assert_async_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_async && !proto_err) |=> !proto_err);
endmodule

bind serial_word_loader slw_checker #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_async (mode_async),
   .sclk       (sclk),
   .latch_req  (latch_req),
   .dac_code   (dac_code),
   .proto_err  (proto_err),
   .frame_err  (frame_err)
);

// File: tb/sim_serial_word_loader.sv
`timescale 1ns/1ps
module sim_serial_word_loader;
   logic        clk = 1'b0;
   logic        rst_n, mode_async, din, sclk, latch_req;
   logic        sdout, proto_err, frame_err;
   logic [15:0] dac_code;
   logic        sdout1, proto_err1, frame_err1;
   logic [15:0] dac_code1;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   serial_word_loader u0 (
      .clk(clk), .rst_n(rst_n), .mode_async(mode_async), .din(din),
      .sclk(sclk), .latch_req(latch_req), .sdout(sdout),
      .dac_code(dac_code), .proto_err(proto_err), .frame_err(frame_err)
   );

   serial_word_loader u1 (
      .clk(clk), .rst_n(rst_n), .mode_async(mode_async), .din(sdout),
      .sclk(sclk), .latch_req(latch_req), .sdout(sdout1),
      .dac_code(dac_code1), .proto_err(proto_err1), .frame_err(frame_err1)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic m);
      @(negedge clk);
      rst_n = 1'b0; mode_async = m; din = 1'b1; sclk = 1'b0; latch_req = 1'b0;
      wait_n(5);
      rst_n = 1'b1;
      wait_n(2);
   endtask

   task automatic sh_bit(input logic b);
      @(negedge clk); din = b; sclk = 1'b0;
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
   endtask

   task automatic sh_word(input logic [15:0] w);
      for (int i = 15; i >= 0; i--) sh_bit(w[i]);
   endtask

   task automatic pulse_latch();
      @(negedge clk); latch_req = 1'b1;
      @(negedge clk); latch_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop);
      @(negedge clk); din = 1'b0; wait_n(15);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); din = b[i]; wait_n(15);
      end
      @(negedge clk); din = stop; wait_n(15);
      @(negedge clk); din = 1'b1;
   endtask

   task automatic t_reset();
      do_reset(1'b0);
      chk("R1 dac_code", dac_code, 0);
      chk("R1 sdout", sdout, 0);
      chk("R1 flags", {proto_err, frame_err}, 0);
      pulse_latch();
      chk("R1 shift register cleared", dac_code, 0);
   endtask

   task automatic t_sync_load();
      do_reset(1'b0);
      sh_word(16'hA5C3);
      chk("R3 no update before latch", dac_code, 0);
      chk("R5 sdout is bit 15", sdout, 1);
      pulse_latch();
      chk("R2 R3 latched word", dac_code, 16'hA5C3);
      sh_word(16'h3C00);
      chk("R5 sdout follows shift", sdout, 0);
      chk("R3 holds until latch", dac_code, 16'hA5C3);
      pulse_latch();
      chk("R2 second word", dac_code, 16'h3C00);
   endtask

   task automatic t_proto();
      do_reset(1'b0);
      sh_word(16'h0F0F);
      @(negedge clk); latch_req = 1'b1;
      wait_n(2);
      for (int i = 0; i < 2; i++) begin
         @(negedge clk); din = 1'b1; sclk = 1'b1;
         @(negedge clk); sclk = 1'b0;
      end
      @(negedge clk); latch_req = 1'b0;
      chk("R4 proto_err set", proto_err, 1);
      chk("R3 load on latch", dac_code, 16'h0F0F);
      pulse_latch();
      chk("R4 edges during latch dropped", dac_code, 16'h0F0F);
      chk("R4 proto_err sticky", proto_err, 1);
   endtask

   task automatic t_collision();
      do_reset(1'b0);
      sh_word(16'h8001);
      @(negedge clk); din = 1'b0; sclk = 1'b1; latch_req = 1'b1;
      @(negedge clk); sclk = 1'b0; latch_req = 1'b0;
      @(negedge clk);
      chk("R4 collision latch pre-edge word", dac_code, 16'h8001);
      chk("R4 collision flag", proto_err, 1);
      pulse_latch();
      chk("R4 collision shift dropped", dac_code, 16'h8001);
   endtask

   task automatic t_chain();
      do_reset(1'b0);
      sh_word(16'hBEEF);
      sh_word(16'h1357);
      pulse_latch();
      chk("R5 far device first word", dac_code1, 16'hBEEF);
      chk("R5 near device last word", dac_code, 16'h1357);
   endtask

   task automatic t_async_word();
      do_reset(1'b1);
      wait_n(4);
      send_frame(8'h3C, 1'b1);
      wait_n(4);
      chk("R7 no load after first frame", dac_code, 0);
      send_frame(8'hD2, 1'b1);
      wait_n(4);
      chk("R6 R7 word loaded", dac_code, 16'h3CD2);
      send_frame(8'hFF, 1'b1);
      send_frame(8'h01, 1'b1);
      wait_n(4);
      chk("R6 LSB-first framing", dac_code, 16'hFF01);
      chk("R8 no frame_err on good frames", frame_err, 0);
   endtask

   task automatic t_async_ferr();
      do_reset(1'b1);
      wait_n(4);
      send_frame(8'h11, 1'b1);
      send_frame(8'h22, 1'b0);
      wait_n(20);
      chk("R8 frame_err set", frame_err, 1);
      chk("R8 no load on bad frame", dac_code, 0);
      send_frame(8'h44, 1'b1);
      send_frame(8'h55, 1'b1);
      wait_n(4);
      chk("R8 partial word discarded", dac_code, 16'h4455);
      chk("R8 frame_err sticky", frame_err, 1);
   endtask

   task automatic t_hold_low();
      do_reset(1'b1);
      wait_n(4);
      @(negedge clk); din = 1'b0;
      wait_n(400);
      @(negedge clk); din = 1'b1;
      wait_n(20);
      chk("R9 low hold gives framing error", frame_err, 1);
      chk("R9 no load from held line", dac_code, 0);
      send_frame(8'hAA, 1'b1);
      send_frame(8'h55, 1'b1);
      wait_n(4);
      chk("R9 no restart while low", dac_code, 16'hAA55);
   endtask

   task automatic t_mode_ignore();
      do_reset(1'b1);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); sclk = 1'b1; latch_req = i[0];
         @(negedge clk); sclk = 1'b0; latch_req = 1'b1;
         @(negedge clk); latch_req = 1'b0;
      end
      wait_n(4);
      chk("R10 async ignores sclk and latch", dac_code, 0);
      chk("R10 async proto_err stays 0", proto_err, 0);
      do_reset(1'b0);
      send_frame(8'h5A, 1'b1);
      send_frame(8'hC3, 1'b1);
      pulse_latch();
      chk("R10 sync ignores frames", dac_code, 0);
   endtask

   initial begin
      rst_n = 1'b0; mode_async = 1'b0; din = 1'b1; sclk = 1'b0; latch_req = 1'b0;
      t_reset();
      t_sync_load();
      t_proto();
      t_collision();
      t_chain();
      t_async_word();
      t_async_ferr();
      t_hold_low();
      t_mode_ignore();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule